// File: doc/BRIEF.md
# Charge-Balancing Integrator Conversion Controller

This block is the digital half of a continuous-integration converter that turns a sensor current into a code. Outside the block, an analog integrator accumulates the input charge without pause. A comparator reports which side of zero the integrator output sits on, and two analog switches can connect a positive or a negative reference to the integrator input. A period tick starts each measurement cycle. On that edge the controller samples the comparator. It then turns on the switch whose reference pushes the integrator back toward zero, and counts clocks until the comparator changes state. At that point it opens the switch and publishes the signed count.

A correction pulse always ends inside the cycle that started it. For that reason exactly one code comes out per period, and the conversion time is set only by the tick spacing, whatever the input amplitude. The pulse width measures the charge collected over the previous interval. If the charge is too large to be cancelled in time, the pulse is cut short and the code saturates with a flag.

Top module: `cbi_adc_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after reset is released, both switch enables, `result_valid`, `overrange` and `result` are 0.
- R2: When idle, a `period_tick` seen at a clock edge starts a cycle and samples `cmp_in` at that edge. From the next clock on, a sample of 1 (integrator above zero) turns on `ref_neg_en` and a sample of 0 turns on `ref_pos_en`.
- R3: The enable is released after the first edge at which `cmp_in` differs from its start sample.
- R4: At the release edge, `result` gets the number of clock periods the enable was high, as a two's-complement value of width clog2(MAX_COUNT+1)+1. The value is positive if the start sample was 1 and negative if it was 0. A normal release sets `overrange` to 0.
- R5: `result_valid` is high for exactly one clock per finished cycle, in the clock right after the release edge. Every pulse on an enable yields exactly one result.
- R6: If the enable has been high for MAX_COUNT clocks with no comparator change, it is released. The result is +MAX_COUNT or -MAX_COUNT and `overrange` is 1. A change seen on that same final edge counts as a normal release.
- R7: A tick that arrives while an enable is high ends the pulse as in R6 (full-scale code, `overrange` 1), unless the comparator changes on that same edge, in which case the release is normal. In both cases the next cycle starts one clock later, sampling `cmp_in` at that edge.
- R8: The two enables are never high together, and at least one clock with both low separates any two pulses.
- R9: `result` and `overrange` hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | Start of a measurement cycle, one clock wide |
| cmp_in | input | 1 | Comparator: 1 when the integrator output is above zero (sense set by CMP_ACTIVE_HIGH) |
| ref_pos_en | output | 1 | Connect the positive reference |
| ref_neg_en | output | 1 | Connect the negative reference |
| result | output | RES_W | Signed pulse duration in clocks |
| result_valid | output | 1 | One-clock strobe for a new result |
| overrange | output | 1 | Last result saturated at full scale |

## Verification
The case that matters most is a period tick landing on the same edge at which the comparator reports the zero crossing. Here the ending of the pulse, the choice between a normal and a saturated code, and the start of the next cycle all meet in one clock. The bench forces this case on purpose and also hits it by chance, with random ticks running against a behavioural integrator. It checks that the code stays the true count without the overrange flag, that the enables go idle for one clock, and that the next pulse's polarity follows the comparator one edge later. The same priority question comes up when the crossing falls exactly on the MAX_COUNT edge, and that case is driven directly as well.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_PULSE = 1'b1
   } cbi_phase_e;

   function automatic int cbi_cnt_width(input int max_count);
      return (max_count < 2) ? 1 : $clog2(max_count + 1);
   endfunction
endpackage

// File: rtl/cbi_cmp_sense.sv
module cbi_cmp_sense #(
   parameter bit CMP_ACTIVE_HIGH = 1'b1
) (
   input  logic cmp_raw,
   output logic integ_above
);
   generate
      if (CMP_ACTIVE_HIGH) begin : g_direct
         assign integ_above = cmp_raw;
      end else begin : g_invert
         assign integ_above = ~cmp_raw;
      end
   endgenerate
endmodule

// File: rtl/cbi_pulse_seq.sv
module cbi_pulse_seq
   import cbi_pkg::*;
#(
   parameter int MAX_COUNT = 1000,
   parameter int CNT_W     = cbi_cnt_width(MAX_COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             integ_above,
   output logic             drive_neg,
   output logic             drive_pos,
   output logic             finish,
   output logic             sat_end,
   output logic             start_above,
   output logic [CNT_W-1:0] on_clocks
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

   cbi_phase_e       phase;
   logic             pol_q;
   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             crossed;
   logic             at_limit;
   logic             begin_cyc;

   assign crossed   = (phase == PH_PULSE) && (integ_above != pol_q);
   assign at_limit  = (cnt_q == LIMIT);
   assign finish    = (phase == PH_PULSE) && (crossed || tick || at_limit);
   assign sat_end   = finish && !crossed;
   assign begin_cyc = (phase == PH_IDLE) && (tick || pend_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         pol_q  <= 1'b0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (begin_cyc) begin
         phase  <= PH_PULSE;
         pol_q  <= integ_above;
         pend_q <= 1'b0;
         cnt_q  <= CNT_W'(1);
      end else if (finish) begin
         phase  <= PH_IDLE;
         pend_q <= tick;
      end else if (phase == PH_PULSE) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign drive_neg   = (phase == PH_PULSE) && pol_q;
   assign drive_pos   = (phase == PH_PULSE) && !pol_q;
   assign start_above = pol_q;
   assign on_clocks   = cnt_q;
endmodule

// File: rtl/cbi_code_reg.sv
module cbi_code_reg #(
   parameter int MAX_COUNT = 1000,
   parameter int CNT_W     = 10,
   parameter int RES_W     = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             finish,
   input  logic             sat_end,
   input  logic             start_above,
   input  logic [CNT_W-1:0] on_clocks,
   output logic [RES_W-1:0] code,
   output logic             code_valid,
   output logic             code_sat
);
   localparam logic [RES_W-1:0] FULL = RES_W'(MAX_COUNT);

   logic [RES_W-1:0] mag;
   logic [RES_W-1:0] signed_code;

   assign mag         = sat_end ? FULL : {1'b0, on_clocks};
   assign signed_code = start_above ? mag : (~mag + RES_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code       <= '0;
         code_valid <= 1'b0;
         code_sat   <= 1'b0;
      end else begin
         code_valid <= finish;
         if (finish) begin
            code     <= signed_code;
            code_sat <= sat_end;
         end
      end
   end
endmodule

// File: rtl/cbi_adc_ctrl.sv
module cbi_adc_ctrl
   import cbi_pkg::*;
#(
   parameter  int MAX_COUNT       = 1000,
   parameter  bit CMP_ACTIVE_HIGH = 1'b1,
   localparam int CNT_W           = cbi_cnt_width(MAX_COUNT),
   localparam int RES_W           = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_tick,
   input  logic             cmp_in,
   output logic             ref_pos_en,
   output logic             ref_neg_en,
   output logic [RES_W-1:0] result,
   output logic             result_valid,
   output logic             overrange
);
   generate
      if (MAX_COUNT < 1) begin : g_bad_max
         $error("cbi_adc_ctrl: MAX_COUNT must be at least 1");
      end
      if (MAX_COUNT > (1 << 24)) begin : g_big_max
         $error("cbi_adc_ctrl: MAX_COUNT above supported range");
      end
   endgenerate

   logic             integ_above;
   logic             finish;
   logic             sat_end;
   logic             start_above;
   logic [CNT_W-1:0] on_clocks;

   cbi_cmp_sense #(
      .CMP_ACTIVE_HIGH(CMP_ACTIVE_HIGH)
   ) u_sense (
      .cmp_raw    (cmp_in),
      .integ_above(integ_above)
   );

   cbi_pulse_seq #(
      .MAX_COUNT(MAX_COUNT),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (period_tick),
      .integ_above(integ_above),
      .drive_neg  (ref_neg_en),
      .drive_pos  (ref_pos_en),
      .finish     (finish),
      .sat_end    (sat_end),
      .start_above(start_above),
      .on_clocks  (on_clocks)
   );

   cbi_code_reg #(
      .MAX_COUNT(MAX_COUNT),
      .CNT_W    (CNT_W),
      .RES_W    (RES_W)
   ) u_code (
      .clk        (clk),
      .rst_n      (rst_n),
      .finish     (finish),
      .sat_end    (sat_end),
      .start_above(start_above),
      .on_clocks  (on_clocks),
      .code       (result),
      .code_valid (result_valid),
      .code_sat   (overrange)
   );
endmodule

// File: rtl/cbi_adc_ctrl_chk.sv
module cbi_adc_ctrl_chk #(
   parameter int MAX_COUNT       = 1000,
   parameter bit CMP_ACTIVE_HIGH = 1'b1,
   parameter int RES_W           = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             period_tick,
   input logic             cmp_in,
   input logic             ref_pos_en,
   input logic             ref_neg_en,
   input logic [RES_W-1:0] result,
   input logic             result_valid,
   input logic             overrange
);
   localparam logic [RES_W-1:0] FS_POS = RES_W'(MAX_COUNT);
   localparam logic [RES_W-1:0] FS_NEG = ~FS_POS + RES_W'(1);

   logic above;
   logic any_on;
   assign above  = CMP_ACTIVE_HIGH ? cmp_in : ~cmp_in;
   assign any_on = ref_pos_en | ref_neg_en;

   AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_pos_en && ref_neg_en)); // R8
   AST_NEG_THEN_NOT_POS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_neg_en |=> !ref_pos_en); // R8
   AST_POS_THEN_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pos_en |=> !ref_neg_en); // R8
   AST_START_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_on && !result_valid && period_tick && above) |=> ref_neg_en); // R2
   AST_START_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_on && !result_valid && period_tick && !above) |=> ref_pos_en); // R2
   AST_RELEASE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_neg_en && !above) |=> !ref_neg_en); // R3
   AST_RELEASE_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pos_en && above) |=> !ref_pos_en); // R3
   AST_VALID_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (!any_on && $past(any_on))); // R4
   AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R5
   AST_SAT_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && overrange) |-> (result == FS_POS || result == FS_NEG)); // R6
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> ($stable(result) && $stable(overrange))); // R9
endmodule

bind cbi_adc_ctrl cbi_adc_ctrl_chk #(
   .MAX_COUNT      (MAX_COUNT),
   .CMP_ACTIVE_HIGH(CMP_ACTIVE_HIGH),
   .RES_W          (RES_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .period_tick (period_tick),
   .cmp_in      (cmp_in),
   .ref_pos_en  (ref_pos_en),
   .ref_neg_en  (ref_neg_en),
   .result      (result),
   .result_valid(result_valid),
   .overrange   (overrange)
);

// File: tb/cbi_adc_ctrl_bench.sv
`timescale 1ns/1ps
module cbi_adc_ctrl_bench;
   localparam int MAXC  = 24;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int RES_W = CNT_W + 1;
   localparam int REFV  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             period_tick = 1'b0;
   logic             cmp_in = 1'b0;
   logic             ref_pos_en, ref_neg_en, result_valid, overrange;
   logic [RES_W-1:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cbi_adc_ctrl #(.MAX_COUNT(MAXC), .CMP_ACTIVE_HIGH(1'b1)) u_cbi_adc_ctrl (
      .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .cmp_in(cmp_in),
      .ref_pos_en(ref_pos_en), .ref_neg_en(ref_neg_en), .result(result),
      .result_valid(result_valid), .overrange(overrange)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int code_of(input bit above, input int mag);
      return above ? mag : -mag;
   endfunction

   // inputs as seen at the last rising edge
   logic tick_d = 1'b0, cmp_d = 1'b0, rst_d = 1'b0;
   always @(posedge clk) begin
      tick_d <= period_tick;
      cmp_d  <= cmp_in;
      rst_d  <= rst_n;
   end

   // expected behaviour from the requirements
   bit m_on = 0, m_pol = 0, m_pend = 0, m_valid = 0, m_ovr = 0;
   int m_cnt = 0, m_res = 0;
   int last_res = 0;
   bit last_ovr = 0;
   bit prev_pos = 0, prev_neg = 0, prev_any = 0;
   int n_starts = 0, n_results = 0;

   always @(negedge clk) begin
      m_valid = 0;
      if (!rst_d) begin
         m_on = 0; m_pend = 0; m_cnt = 0; m_res = 0; m_ovr = 0;
      end else if (m_on) begin
         if (cmp_d != m_pol) begin
            m_res = code_of(m_pol, m_cnt); m_ovr = 0; m_valid = 1; m_on = 0; m_pend = tick_d;
         end else if (tick_d || m_cnt == MAXC) begin
            m_res = code_of(m_pol, MAXC); m_ovr = 1; m_valid = 1; m_on = 0; m_pend = tick_d;
         end else begin
            m_cnt++;
         end
      end else if (tick_d || m_pend) begin
         m_on = 1; m_pol = cmp_d; m_cnt = 1; m_pend = 0;
      end
      if (!rst_d) begin
         chk(!ref_pos_en && !ref_neg_en && !result_valid && !overrange && result == '0,
             "R1 reset state", int'(result), 0);
      end else begin
         chk(ref_neg_en == (m_on && m_pol), "R2 negative enable", ref_neg_en, m_on && m_pol);
         chk(ref_pos_en == (m_on && !m_pol), "R3 positive enable", ref_pos_en, m_on && !m_pol);
         chk(result_valid == m_valid, "R5 valid strobe", result_valid, m_valid);
         chk(int'($signed(result)) == m_res, m_valid ? "R4 signed code" : "R9 held code",
             int'($signed(result)), m_res);
         chk(overrange == m_ovr, m_valid ? "R6 overrange flag" : "R9 held flag", overrange, m_ovr);
      end
      chk(!(ref_pos_en && ref_neg_en), "R8 exclusive enables", ref_pos_en + ref_neg_en, 1);
      chk(!(ref_pos_en && prev_neg) && !(ref_neg_en && prev_pos), "R8 idle gap", 1, 0);
      if ((ref_pos_en || ref_neg_en) && !prev_any) n_starts++;
      if (result_valid) begin
         n_results++;
         last_res = int'($signed(result));
         last_ovr = overrange;
      end
      prev_pos = ref_pos_en; prev_neg = ref_neg_en; prev_any = ref_pos_en || ref_neg_en;
   end

   // directed cycle: polarity p, crossing at pulse clock d (0 = never),
   // tick at pulse clock tk (0 = none), new start sample p2 after a tick end
   task automatic run_dir(input bit p, input int d, input int tk, input bit p2);
      int e;
      e = MAXC;
      if (d != 0 && d < e) e = d;
      if (tk != 0 && tk < e) e = tk;
      @(negedge clk); cmp_in = p; period_tick = 1'b1;
      for (int k = 1; k <= e; k++) begin
         @(negedge clk);
         period_tick = (k == tk);
         if (k == d) cmp_in = !p;
      end
      @(negedge clk); period_tick = 1'b0;
      if (tk != 0 && tk == e) begin
         cmp_in = p2;
         @(negedge clk); cmp_in = !p2;
      end
      repeat (4) @(negedge clk);
   endtask

   int integ = 0;
   int drive_in = 0;

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      run_dir(1'b1, 3, 0, 1'b0);
      chk(last_res == 3 && !last_ovr, "R4 directed positive code", last_res, 3);
      run_dir(1'b0, 1, 0, 1'b0);
      chk(last_res == -1 && !last_ovr, "R3 one-clock negative pulse", last_res, -1);
      run_dir(1'b1, 0, 0, 1'b0);
      chk(last_res == MAXC && last_ovr, "R6 saturate positive", last_res, MAXC);
      run_dir(1'b0, MAXC, 0, 1'b0);
      chk(last_res == -MAXC && !last_ovr, "R6 crossing on limit edge", last_res, -MAXC);
      run_dir(1'b1, 0, 5, 1'b0);
      chk(last_res == -1 && !last_ovr, "R7 restart after tick cut", last_res, -1);
      run_dir(1'b0, 4, 4, 1'b1);
      chk(last_res == 1 && !last_ovr, "R7 crossing and tick together", last_res, 1);
      cmp_in = 1'b0;
      repeat (6) @(negedge clk);

      // random run against a behavioural integrator
      for (int c = 0; c < 12000; c++) begin
         if (c % 250 == 0) drive_in = int'($urandom_range(0, 8)) - 4;
         if (c % 1000 == 999) drive_in = 9;
         integ += drive_in + (ref_pos_en ? REFV : 0) - (ref_neg_en ? REFV : 0);
         cmp_in = (integ > 0);
         if (c < 6000) period_tick = (c % 30 == 0);
         else period_tick = ($urandom_range(0, 99) < 6);
         @(negedge clk);
      end
      period_tick = 1'b0;
      repeat (MAXC + 8) @(negedge clk);
      chk(n_starts == n_results, "R5 one result per pulse", n_results, n_starts);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule